// File: doc/BRIEF.md
# Cycle Counter Compare Timer

This block keeps a free-running 32-bit cycle count and a configurable set of compare registers. Each comparator owns one interrupt line, which goes high and stays high once the count passes over the comparator's value. The count normally moves forward by one per enabled clock. A multi-cycle advance lets a core that was halted catch up in a single clock. Matching works on a wraparound window, so a large jump cannot skip a compare value.

The block also gives a wake target. This is the compare value nearest ahead of the count, and a power controller can use it to arm its wake-up timer. A skip request moves the count straight past that target in one clock. A simple write port loads the count or any compare register. All pins are plain control and status signals. There is no streaming interface and no back-pressure: every request is taken in the clock it is presented.

Top module: `cct_timer`

## Requirements
- R1: After reset the count is 0, every interrupt line is low, every compare register holds 0, and so the wake target is 0.
- R2: With `tick_en` high and no load, skip or advance, the count rises by exactly 1 (mod 2^32). With no request at all, the count and the interrupts hold.
- R3: A write with `wr_sel` = 0 loads `wr_data` into the count. It takes priority over skip, advance and tick in the same clock, and that clock checks no matches.
- R4: A step of d cycles sets interrupt i when (cmp_i - (count + 1)) mod 2^32 < d, where count is the value before the step. This includes windows that wrap past 0. A step of zero matches nothing.
- R5: While `timer_on` is low, no interrupt line is set.
- R6: An interrupt line stays high until its compare register is written (`wr_sel` = i + 1). That write clears it, even if the old value matches in the same clock.
- R7: The wake target starts as count - 1. It is replaced, in index order, by any compare value whose forward distance (cmp - count) mod 2^32 is strictly smaller than the current candidate's. Ties keep the lower index.
- R8: `skip_to_wake` checks matches over a step of d = (wake - count) mod 2^32 and then sets the count to wake + 1.
- R9: Step sources rank as follows: skip, then advance, then tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_on | input | 1 | Enables compare matching |
| tick_en | input | 1 | Advance the count by one |
| adv_valid | input | 1 | Apply `adv_amount` this clock |
| adv_amount | input | 32 | Multi-cycle advance amount |
| skip_to_wake | input | 1 | Jump the count past the wake target |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | 0 = count, i + 1 = compare i |
| wr_data | input | 32 | Write data |
| count | output | 32 | Current cycle count |
| wake_target | output | 32 | Nearest compare value ahead of the count |
| timer_irq | output | IRQ_W | One sticky interrupt per comparator |

## Verification
On every cycle, the assertions check the following. A single tick moves the count by one. A load and a skip produce the count they promise. Nothing moves when no request is present. An interrupt is never raised while matching is off. A pending interrupt only drops when its compare register is written. Only the bench's scenarios can show that the wraparound window catches compare values in a large jump, including across zero. They also show that the wake target picks the nearest compare value, that the skip window covers that target, and how the step sources rank against each other.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int CNT_W = 32;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_LOAD,
    ST_SKIP,
    ST_ADV,
    ST_TICK
  } step_e;

  // forward distance from base to target, modulo 2^CNT_W
  function automatic cnt_t fwd_dist(input cnt_t target, input cnt_t base);
    return target - base;
  endfunction
endpackage

// File: rtl/cct_step_ctl.sv
module cct_step_ctl
  import cct_pkg::*;
(
  input  logic  load_req,
  input  cnt_t  load_val,
  input  logic  skip_req,
  input  logic  adv_req,
  input  cnt_t  adv_amt,
  input  logic  tick_req,
  input  cnt_t  cur_count,
  input  cnt_t  wake,
  output step_e step_kind,
  output cnt_t  delta,
  output cnt_t  next_count,
  output logic  check_en
);
  always_comb begin
    if (load_req)      step_kind = ST_LOAD;
    else if (skip_req) step_kind = ST_SKIP;
    else if (adv_req)  step_kind = ST_ADV;
    else if (tick_req) step_kind = ST_TICK;
    else               step_kind = ST_HOLD;
  end

  always_comb begin
    delta      = '0;
    next_count = cur_count;
    check_en   = 1'b0;
    unique case (step_kind)
      ST_LOAD: begin
        next_count = load_val;
      end
      ST_SKIP: begin
        delta      = fwd_dist(wake, cur_count);
        next_count = wake + cnt_t'(1);
        check_en   = 1'b1;
      end
      ST_ADV: begin
        delta      = adv_amt;
        next_count = cur_count + adv_amt;
        check_en   = 1'b1;
      end
      ST_TICK: begin
        delta      = cnt_t'(1);
        next_count = cur_count + cnt_t'(1);
        check_en   = 1'b1;
      end
      default: begin
        next_count = cur_count;
      end
    endcase
  end
endmodule

// File: rtl/cct_counter.sv
module cct_counter
  import cct_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cnt_t next_count,
  output cnt_t count_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= next_count;
  end
endmodule

// File: rtl/cct_cmp_unit.sv
module cct_cmp_unit
  import cct_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  cnt_t wr_data,
  input  cnt_t cur_count,
  input  cnt_t delta,
  input  logic check_en,
  output cnt_t cmp_val,
  output logic irq
);
  cnt_t offs;
  logic hit;

  // the window starts at the first value newly reached
  assign offs = fwd_dist(cmp_val, cur_count + cnt_t'(1));
  assign hit  = check_en && (offs < delta);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_val <= '0;
      irq     <= 1'b0;
    end else if (wr_hit) begin
      cmp_val <= wr_data;
      irq     <= 1'b0;
    end else if (hit) begin
      irq     <= 1'b1;
    end
  end
endmodule

// File: rtl/cct_wake_sel.sv
module cct_wake_sel
  import cct_pkg::*;
#(
  parameter int N = 3
) (
  input  cnt_t                   cur_count,
  input  logic [N-1:0][CNT_W-1:0] cmp_flat,
  output cnt_t                   wake
);
  always_comb begin
    cnt_t best_d;
    cnt_t d;
    best_d = '1;
    wake   = cur_count - cnt_t'(1);
    for (int i = 0; i < N; i++) begin
      d = fwd_dist(cmp_flat[i], cur_count);
      if (d < best_d) begin
        best_d = d;
        wake   = cmp_flat[i];
      end
    end
  end
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter  int NUM_CMP = 3,
  localparam int SEL_W   = (NUM_CMP < 1) ? 1 : $clog2(NUM_CMP + 1),
  localparam int IRQ_W   = (NUM_CMP > 0) ? NUM_CMP : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             timer_on,
  input  logic             tick_en,
  input  logic             adv_valid,
  input  logic [31:0]      adv_amount,
  input  logic             skip_to_wake,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [31:0]      wr_data,
  output logic [31:0]      count,
  output logic [31:0]      wake_target,
  output logic [IRQ_W-1:0] timer_irq
);
  step_e step_kind;
  cnt_t  delta;
  cnt_t  next_count;
  logic  check_en;
  logic  load_req;
  cnt_t  wake_w;

  assign load_req = wr_en && (wr_sel == '0);

  cct_step_ctl u_step (
    .load_req  (load_req),
    .load_val  (wr_data),
    .skip_req  (skip_to_wake),
    .adv_req   (adv_valid),
    .adv_amt   (adv_amount),
    .tick_req  (tick_en),
    .cur_count (count),
    .wake      (wake_w),
    .step_kind (step_kind),
    .delta     (delta),
    .next_count(next_count),
    .check_en  (check_en)
  );

  cct_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .next_count(next_count),
    .count_q   (count)
  );

  generate
    if (NUM_CMP > 0) begin : g_cmp
      logic [NUM_CMP-1:0][CNT_W-1:0] cmp_flat;
      for (genvar i = 0; i < NUM_CMP; i++) begin : g_unit
        cct_cmp_unit u_unit (
          .clk      (clk),
          .rst_n    (rst_n),
          .wr_hit   (wr_en && (wr_sel == SEL_W'(i + 1))),
          .wr_data  (wr_data),
          .cur_count(count),
          .delta    (delta),
          .check_en (check_en && timer_on),
          .cmp_val  (cmp_flat[i]),
          .irq      (timer_irq[i])
        );
      end
      cct_wake_sel #(.N(NUM_CMP)) u_wake (
        .cur_count(count),
        .cmp_flat (cmp_flat),
        .wake     (wake_w)
      );
    end else begin : g_none
      assign timer_irq = '0;
      assign wake_w    = count - cnt_t'(1);
    end
  endgenerate

  assign wake_target = wake_w;
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk #(
  parameter  int NUM_CMP = 3,
  localparam int SEL_W   = (NUM_CMP < 1) ? 1 : $clog2(NUM_CMP + 1),
  localparam int IRQ_W   = (NUM_CMP > 0) ? NUM_CMP : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             timer_on,
  input logic             tick_en,
  input logic             adv_valid,
  input logic             skip_to_wake,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic [31:0]      wr_data,
  input logic [31:0]      count,
  input logic [31:0]      wake_target,
  input logic [IRQ_W-1:0] timer_irq
);
  logic cnt_wr;
  assign cnt_wr = wr_en && (wr_sel == '0);

  a_r2_tick_one: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !adv_valid && !skip_to_wake && !cnt_wr)
      |=> count == $past(count) + 32'd1);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !adv_valid && !skip_to_wake && !wr_en)
      |=> ($stable(count) && $stable(timer_irq)));

  a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == $past(wr_data));

  a_r5_off_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
    !timer_on |=> (timer_irq & ~$past(timer_irq)) == '0);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (timer_irq & $past(timer_irq)) == $past(timer_irq));

  a_r8_skip_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_to_wake && !cnt_wr) |=> count == $past(wake_target) + 32'd1);
endmodule

bind cct_timer cct_timer_chk #(.NUM_CMP(NUM_CMP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .timer_on    (timer_on),
  .tick_en     (tick_en),
  .adv_valid   (adv_valid),
  .skip_to_wake(skip_to_wake),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .count       (count),
  .wake_target (wake_target),
  .timer_irq   (timer_irq)
);

// File: tb/cct_timer_tb.sv
`timescale 1ns/1ps
module cct_timer_tb;
  localparam int NC = 3;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          timer_on = 1'b0, tick_en = 1'b0, adv_valid = 1'b0, skip_to_wake = 1'b0;
  logic [31:0]   adv_amount = '0;
  logic          wr_en = 1'b0;
  logic [SW-1:0] wr_sel = '0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   count, wake_target;
  logic [NC-1:0] timer_irq;

  always #2.5 clk = ~clk;

  cct_timer #(.NUM_CMP(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .timer_on(timer_on), .tick_en(tick_en),
    .adv_valid(adv_valid), .adv_amount(adv_amount), .skip_to_wake(skip_to_wake),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count(count), .wake_target(wake_target), .timer_irq(timer_irq)
  );

  typedef struct {
    logic [31:0]   c;
    logic [NC-1:0] irq;
    logic [31:0]   w;
    string         tag;
  } exp_t;

  exp_t          q[$];
  exp_t          cur;
  int            n_chk = 0, n_bad = 0;
  logic [31:0]   m_cnt = '0;
  logic [31:0]   m_cmp [NC];
  logic [NC-1:0] m_irq = '0;

  // R7: nearest compare ahead, seeded with count-1, strict-less replacement
  function automatic logic [31:0] exp_wake(input logic [31:0] c);
    logic [31:0] best_d = 32'hFFFF_FFFF;
    logic [31:0] w = c - 32'd1;
    for (int i = 0; i < NC; i++) begin
      if ((m_cmp[i] - c) < best_d) begin
        best_d = m_cmp[i] - c;
        w = m_cmp[i];
      end
    end
    return w;
  endfunction

  task automatic apply(input string tag, input bit tk, input bit av, input logic [31:0] amt,
                       input bit sk, input bit ton, input bit we, input int sel,
                       input logic [31:0] wd);
    logic [31:0] d, nc, wk;
    bit chk;
    exp_t e;
    @(negedge clk);
    tick_en = tk; adv_valid = av; adv_amount = amt; skip_to_wake = sk;
    timer_on = ton; wr_en = we; wr_sel = SW'(sel); wr_data = wd;
    wk = exp_wake(m_cnt);
    d = '0; chk = 0; nc = m_cnt;
    if (we && sel == 0) nc = wd;                                      // R3
    else if (sk) begin d = wk - m_cnt; nc = wk + 32'd1; chk = 1; end  // R8, R9
    else if (av) begin d = amt; nc = m_cnt + amt; chk = 1; end
    else if (tk) begin d = 32'd1; nc = m_cnt + 32'd1; chk = 1; end
    for (int i = 0; i < NC; i++) begin
      if (we && sel == i + 1) begin m_irq[i] = 1'b0; m_cmp[i] = wd; end        // R6
      else if (ton && chk && ((m_cmp[i] - (m_cnt + 32'd1)) < d)) m_irq[i] = 1'b1; // R4, R5
    end
    m_cnt = nc;
    e.c = m_cnt; e.irq = m_irq; e.w = exp_wake(m_cnt); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    apply(tag, 0, 0, 32'd0, 0, 1, 0, 0, 32'd0);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      cur = q.pop_front();
      n_chk++;
      if (count !== cur.c || timer_irq !== cur.irq || wake_target !== cur.w) begin
        n_bad++;
        $display("FAIL %s: count=%h irq=%b wake=%h expected count=%h irq=%b wake=%h",
                 cur.tag, count, timer_irq, wake_target, cur.c, cur.irq, cur.w);
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) m_cmp[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (count !== 32'd0 || timer_irq !== '0 || wake_target !== 32'd0) begin
      n_bad++;
      $display("FAIL R1 reset: count=%h irq=%b wake=%h expected 0 0 0", count, timer_irq, wake_target);
    end
    // R2 ticks and hold
    apply("R2 tick", 1, 0, 0, 0, 1, 0, 0, 0);
    apply("R2 tick", 1, 0, 0, 0, 1, 0, 0, 0);
    apply("R2 tick", 1, 0, 0, 0, 1, 0, 0, 0);
    idle("R2 hold");
    // R7 compare setup
    apply("R7 cmp0", 0, 0, 0, 0, 1, 1, 1, 32'd10);
    apply("R7 cmp1", 0, 0, 0, 0, 1, 1, 2, 32'd6);
    apply("R7 cmp2", 0, 0, 0, 0, 1, 1, 3, 32'hFFFF_FFF0);
    apply("R4 tick", 1, 0, 0, 0, 1, 0, 0, 0);
    apply("R4 tick", 1, 0, 0, 0, 1, 0, 0, 0);
    apply("R4 tick hits cmp1", 1, 0, 0, 0, 1, 0, 0, 0);
    apply("R4 zero advance", 0, 1, 32'd0, 0, 1, 0, 0, 0);
    apply("R4 advance 100", 0, 1, 32'd100, 0, 1, 0, 0, 0);
    apply("R6 clear cmp1", 0, 0, 0, 0, 1, 1, 2, 32'd200);
    apply("R5 timer off", 0, 1, 32'd200, 0, 0, 0, 0, 0);
    apply("R3 load beats advance", 1, 1, 32'h8000_0000, 0, 1, 1, 0, 32'hFFFF_FFE0);
    apply("R6 cmp0 write", 0, 0, 0, 0, 1, 1, 1, 32'd5);
    apply("R7 cmp1 wrap", 0, 0, 0, 0, 1, 1, 2, 32'h10);
    apply("R8 skip to wake", 0, 0, 0, 1, 1, 0, 0, 0);
    apply("R4 wrap window", 0, 1, 32'h20, 0, 1, 0, 0, 0);
    apply("R6 clr0", 0, 0, 0, 0, 1, 1, 1, 32'h40);
    apply("R6 clr1", 0, 0, 0, 0, 1, 1, 2, 32'h80);
    apply("R6 clr2", 0, 0, 0, 0, 1, 1, 3, 32'h30);
    apply("R9 skip over adv", 1, 1, 32'd5, 1, 1, 0, 0, 0);
    apply("R9 adv over tick", 1, 1, 32'd7, 0, 1, 0, 0, 0);
    apply("R6 clear wins", 0, 1, 32'h20, 0, 1, 1, 1, 32'h99);
    apply("R7 equal cmps", 0, 0, 0, 0, 1, 1, 2, 32'h99);
    apply("R8 skip tie", 0, 0, 0, 1, 1, 0, 0, 0);
    apply("R8 skip no-work", 0, 0, 0, 1, 1, 0, 0, 0);
    idle("R2 final hold");
    idle("R2 final hold");
    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule